// File: doc/BRIEF.md
# Sixteen-bit Timer with Two Compare Channels and One Capture Channel

The block is a 16-bit event timer for a microcontroller-class subsystem. The timer steps only on a chosen tick source. That source is one of three: an internal divided tick, an external clock input that steps on its rising edge, or the same input stepping on its falling edge. If no source is selected, the timer is stopped. The count runs upward to a programmable limit and wraps to zero. It can also run downward from zero to the limit. Either wrap records an overflow.

Two compare channels watch the count. Each channel holds a staged value and a live value. Software writes the staged value. The live value is the one compared after every step, and it takes the staged value only at the end of a counting period. One capture channel takes one of two input pins. It synchronizes the pin, rejects short glitches, and detects the programmed edge. On that edge it records the current count.

Every event sets a sticky flag. Software clears a flag by writing a one to it. A per-event mask gates each flag onto its own interrupt line. All configuration goes through a single-cycle write port.

Top module: `cmpcap_timer`

## Requirements
- R1: After reset the count, the capture value, all flags, all masks and all interrupt lines are zero, the clock source is off and the limit is all ones.
- R2: The control register is at address 0. Its bits [1:0] select the tick source: 0 is off, 1 is an internal tick every PRE_DIV cycles, 2 is a rising edge of `ext_clk_in`, and 3 is a falling edge of `ext_clk_in`. The count takes exactly one step per tick.
- R3: While the source is off, the count holds its value whatever the clock input does. No overflow or compare flag is set.
- R4: When control bit 2 is 0 the count goes up. A step at the limit (address 1) gives 0. When bit 2 is 1 the count goes down, and a step at 0 gives the limit. Both wraps set flag bit 0 (overflow).
- R5: A step that leaves the count equal to a channel's live compare value sets that channel's flag: bit 1 for channel A and bit 2 for channel B.
- R6: Writes to address 5 (A) or 6 (B) go to a staged register. While a source is selected, the live value takes the staged value only on a wrap step. While the source is off, a write reaches the live value at once.
- R7: Control bit 3 selects the capture pin: 0 for `cap_in_a`, 1 for `cap_in_b`. Control bit 4 selects the capture edge: 0 for rising, 1 for falling. A filtered edge of the selected kind copies the count into `capture_o` and sets flag bit 3. The other pin and the other edge have no effect.
- R8: The capture filter changes state only after 4 consecutive equal synchronized samples. A shorter pulse captures nothing.
- R9: Writing to address 4 clears each flag whose data bit is 1 and leaves the others untouched. If a set and a clear reach the same flag in the same cycle, the flag stays set.
- R10: `irq_o[i]` is high exactly when flag i is set and bit i of the mask register (address 3) is 1.
- R11: A write to address 2 loads the count directly. It takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| ext_clk_in | input | 1 | External tick input, asynchronous |
| cap_in_a | input | 1 | Capture pin A, asynchronous |
| cap_in_b | input | 1 | Capture pin B, asynchronous |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Last captured count |
| flags_o | output | 4 | Flags: [0] overflow, [1] compare A, [2] compare B, [3] capture |
| irq_o | output | 4 | Per-flag masked interrupt lines |

## Verification
The assertions assume that a register write reaches the design only through the write port. They also assume that `ext_clk_in` holds each level long enough for the synchronizer to see every edge. The bench holds each level for three cycles, and it changes the capture select only while both capture pins are low. Under these conditions no edge appears purely from the switch. Capture is checked with the counter stopped, so the expected capture value is the loaded count and does not depend on the filter latency. The set-versus-clear case is timed by counting the synchronizer and step registers from the input change.

// File: rtl/tmr_pkg.sv
// Shared types and address map for the compare/capture timer.
// Assumes a 3-bit register address; compare channels sit from CMP_BASE up.
package tmr_pkg;

    typedef enum logic [1:0] {
        CLK_OFF      = 2'd0,
        CLK_PRESCALE = 2'd1,
        CLK_EXT_RISE = 2'd2,
        CLK_EXT_FALL = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic     cap_fall;
        logic     cap_sel;
        logic     down;
        clk_src_e src;
    } ctrl_t;

    localparam int          ADDR_W    = 3;
    localparam int          CTRL_W    = $bits(ctrl_t);
    localparam logic [2:0]  AD_CTRL   = 3'd0;
    localparam logic [2:0]  AD_TOP    = 3'd1;
    localparam logic [2:0]  AD_COUNT  = 3'd2;
    localparam logic [2:0]  AD_MASK   = 3'd3;
    localparam logic [2:0]  AD_CLEAR  = 3'd4;
    localparam logic [2:0]  AD_CMP0   = 3'd5;

endpackage

// File: rtl/tmr_tick_gen.sv
// Tick source: internal divider or synchronized external edge.
// Assumes PRE_DIV >= 2 and SYNC_STAGES >= 2; ext_pin is asynchronous.
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int PRE_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src,
    input  logic     ext_pin,
    output logic     tick
);

    localparam int           PW       = $clog2(PRE_DIV);
    localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0]          pre_cnt;
    logic [SYNC_STAGES-1:0] ext_sync;
    logic                   ext_prev;
    logic                   ext_rise;
    logic                   ext_fall;

    // Divider runs only while the internal source is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pre_cnt <= '0;
        else if (src != CLK_PRESCALE) pre_cnt <= '0;
        else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
        else                          pre_cnt <= pre_cnt + 1'b1;
    end

    // Synchronizer chain plus previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sync <= '0;
            ext_prev <= 1'b0;
        end else begin
            ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_pin};
            ext_prev <= ext_sync[SYNC_STAGES-1];
        end
    end

    assign ext_rise = ext_sync[SYNC_STAGES-1] & ~ext_prev;
    assign ext_fall = ~ext_sync[SYNC_STAGES-1] & ext_prev;

    // Pick the tick according to the selected source.
    always_comb begin
        unique case (src)
            CLK_PRESCALE: tick = (pre_cnt == PRE_LAST);
            CLK_EXT_RISE: tick = ext_rise;
            CLK_EXT_FALL: tick = ext_fall;
            default:      tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_counter.sv
// Up/down counter between zero and a programmable limit.
// Assumes ld_en has priority over tick; wrap_step marks a period boundary.
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         down,
    input  logic [W-1:0] top,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] count,
    output logic         wrap_step,
    output logic         stepped
);

    logic at_end;

    assign at_end    = down ? (count == '0) : (count >= top);
    assign wrap_step = tick && !ld_en && at_end;

    // Count register: load, wrap, or single step.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (ld_en)  count <= ld_val;
        else if (tick) begin
            if (at_end)  count <= down ? top : '0;
            else         count <= down ? count - 1'b1 : count + 1'b1;
        end
    end

    // Remembers that the count just moved, for compare evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) stepped <= 1'b0;
        else        stepped <= tick && !ld_en;
    end

endmodule

// File: rtl/tmr_cmp_chan.sv
// One compare channel with a staged and a live compare value.
// Assumes reload pulses on wrap steps; pass_through when the timer is off.
module tmr_cmp_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         pass_through,
    input  logic         reload,
    input  logic         stepped,
    input  logic [W-1:0] count,
    output logic [W-1:0] active,
    output logic         match
);

    logic [W-1:0] staged;

    // Staged value follows every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     staged <= '0;
        else if (wr_en) staged <= wr_val;
    end

    // Live value: direct when stopped, otherwise only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                      active <= '0;
        else if (wr_en && pass_through)  active <= wr_val;
        else if (reload)                 active <= staged;
    end

    assign match = stepped && (count == active);

endmodule

// File: rtl/tmr_capture.sv
// Capture path: pin select, synchronizer, glitch filter, edge detect, latch.
// Assumes the pins are asynchronous; FILT_LEN >= 2, SYNC_STAGES >= 2.
module tmr_capture #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin_a,
    input  logic         pin_b,
    input  logic         sel_b,
    input  logic         on_fall,
    input  logic [W-1:0] count,
    output logic         cap_evt,
    output logic [W-1:0] cap_val
);

    logic [1:0]          pins;
    logic [1:0]          synced;
    logic                sample;
    logic [FILT_LEN-1:0] hist;
    logic                filt;
    logic                filt_prev;

    assign pins = {pin_b, pin_a};

    for (genvar p = 0; p < 2; p++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Per-pin synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], pins[p]};
        end
        assign synced[p] = chain[SYNC_STAGES-1];
    end

    assign sample = sel_b ? synced[1] : synced[0];

    // Sample history and filtered level that needs a full run of equal samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist      <= '0;
            filt      <= 1'b0;
            filt_prev <= 1'b0;
        end else begin
            hist      <= {hist[FILT_LEN-2:0], sample};
            filt_prev <= filt;
            if (&hist)       filt <= 1'b1;
            else if (~|hist) filt <= 1'b0;
        end
    end

    assign cap_evt = on_fall ? (filt_prev & ~filt) : (filt & ~filt_prev);

    // Capture register takes the count on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_val <= '0;
        else if (cap_evt) cap_val <= count;
    end

endmodule

// File: rtl/cmpcap_timer.sv
// Timer top: register file, tick source, counter, compare channels,
// capture channel, sticky flags and masked interrupts.
// Assumes single-cycle writes; flags order: overflow, compares, capture.
module cmpcap_timer
    import tmr_pkg::*;
#(
    parameter int W           = 16,
    parameter int PRE_DIV     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int NUM_CMP     = 2,
    localparam int NFLAG      = NUM_CMP + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              ext_clk_in,
    input  logic              cap_in_a,
    input  logic              cap_in_b,
    output logic [W-1:0]      count_o,
    output logic [W-1:0]      capture_o,
    output logic [NFLAG-1:0]  flags_o,
    output logic [NFLAG-1:0]  irq_o
);

    localparam int FLAG_OVF = 0;
    localparam int FLAG_CAP = NUM_CMP + 1;

    ctrl_t             ctrl_q;
    logic [W-1:0]      top_q;
    logic [NFLAG-1:0]  mask_q;
    logic [NFLAG-1:0]  flags_q;
    logic [NFLAG-1:0]  clr_vec;
    logic [NFLAG-1:0]  set_vec;
    logic              tick;
    logic              count_wr;
    logic              wrap_step;
    logic              stepped;
    logic              cap_evt;
    logic [NUM_CMP-1:0] match;
    logic [W-1:0]      cmp_active [NUM_CMP];

    assign count_wr = wr_en && (wr_addr == AD_COUNT);
    assign clr_vec  = (wr_en && wr_addr == AD_CLEAR) ? wr_data[NFLAG-1:0] : '0;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            top_q  <= '1;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == AD_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_addr == AD_TOP)  top_q  <= wr_data;
            if (wr_addr == AD_MASK) mask_q <= wr_data[NFLAG-1:0];
        end
    end

    tmr_tick_gen #(
        .PRE_DIV     (PRE_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (ctrl_q.src),
        .ext_pin (ext_clk_in),
        .tick    (tick)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .down      (ctrl_q.down),
        .top       (top_q),
        .ld_en     (count_wr),
        .ld_val    (wr_data),
        .count     (count_o),
        .wrap_step (wrap_step),
        .stepped   (stepped)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] CMP_ADDR = AD_CMP0 + ADDR_W'(i);
        tmr_cmp_chan #(.W(W)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (wr_en && wr_addr == CMP_ADDR),
            .wr_val       (wr_data),
            .pass_through (ctrl_q.src == CLK_OFF),
            .reload       (wrap_step),
            .stepped      (stepped),
            .count        (count_o),
            .active       (cmp_active[i]),
            .match        (match[i])
        );
    end

    tmr_capture #(
        .W           (W),
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_a   (cap_in_a),
        .pin_b   (cap_in_b),
        .sel_b   (ctrl_q.cap_sel),
        .on_fall (ctrl_q.cap_fall),
        .count   (count_o),
        .cap_evt (cap_evt),
        .cap_val (capture_o)
    );

    // Gather per-event set pulses into flag order.
    always_comb begin
        set_vec                        = '0;
        set_vec[FLAG_OVF]              = wrap_step;
        set_vec[NUM_CMP:1]             = match;
        set_vec[FLAG_CAP]              = cap_evt;
    end

    // Sticky flags: clear by writing one, a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    assign flags_o = flags_q;
    assign irq_o   = flags_q & mask_q;

endmodule

// File: rtl/tmr_checker.sv
// Property checker for cmpcap_timer, bound into every instance.
// Assumes it observes the top's own registers and write port.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int W     = 16,
    parameter int NFLAG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NFLAG-1:0]  clr_data,
    input clk_src_e          src,
    input logic              down,
    input logic              tick,
    input logic              ld_en,
    input logic              wrap_step,
    input logic [W-1:0]      count,
    input logic [W-1:0]      top,
    input logic [W-1:0]      cmp_live,
    input logic              cap_evt,
    input logic [W-1:0]      capture,
    input logic [NFLAG-1:0]  flags
);

    logic [NFLAG-1:0] clr_seen;
    assign clr_seen = (wr_en && wr_addr == AD_CLEAR) ? clr_data : '0;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (src == CLK_OFF && !ld_en) |=> $stable(count)); // R3

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !down && !ld_en && count < top) |=> (count == W'($past(count) + 1'b1))); // R4

    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_step |=> flags[0]); // R4

    AST_LIVE_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (src != CLK_OFF && !wrap_step) |=> $stable(cmp_live)); // R6

    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (capture == $past(count) && flags[NFLAG-1])); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(flags) & ~$past(clr_seen)) & ~flags) == '0)); // R9

endmodule

bind cmpcap_timer tmr_checker #(.W(W), .NFLAG(NFLAG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .clr_data  (wr_data[NFLAG-1:0]),
    .src       (ctrl_q.src),
    .down      (ctrl_q.down),
    .tick      (tick),
    .ld_en     (count_wr),
    .wrap_step (wrap_step),
    .count     (count_o),
    .top       (top_q),
    .cmp_live  (cmp_active[0]),
    .cap_evt   (cap_evt),
    .capture   (capture_o),
    .flags     (flags_q)
);

// File: tb/cmpcap_timer_tb_top.sv
`timescale 1ns/1ps
module cmpcap_timer_tb_top;

    localparam int PRE_DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ext_clk_in = 1'b0;
    logic        cap_in_a = 1'b0;
    logic        cap_in_b = 1'b0;
    logic [15:0] count_o;
    logic [15:0] capture_o;
    logic [3:0]  flags_o;
    logic [3:0]  irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cmpcap_timer #(.PRE_DIV(PRE_DIV)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ext_clk_in (ext_clk_in),
        .cap_in_a   (cap_in_a),
        .cap_in_b   (cap_in_b),
        .count_o    (count_o),
        .capture_o  (capture_o),
        .flags_o    (flags_o),
        .irq_o      (irq_o)
    );

    typedef struct packed {
        logic [15:0] top;
        logic [15:0] cmp_a;
        logic [15:0] cmp_b;
        logic [15:0] start;
        logic        down;
        logic [7:0]  steps;
        logic [15:0] exp_count;
        logic [3:0]  exp_flags;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'd9,     16'd3, 16'd12,    16'd0,     1'b0, 8'd5, 16'd5,  4'b0010},
        '{16'd9,     16'd3, 16'd8,     16'd7,     1'b0, 8'd4, 16'd1,  4'b0101},
        '{16'd5,     16'd0, 16'd2,     16'd2,     1'b1, 8'd4, 16'd4,  4'b0011},
        '{16'hFFFF,  16'd1, 16'hFFFF,  16'hFFFE,  1'b0, 8'd3, 16'd1,  4'b0111},
        '{16'd3,     16'd3, 16'd3,     16'd0,     1'b0, 8'd0, 16'd0,  4'b0000},
        '{16'd20,    16'd7, 16'd7,     16'd0,     1'b1, 8'd1, 16'd20, 4'b0001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_ext(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ext_clk_in = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic hold_pin(input bit use_b, input bit level, input int cycles);
        @(negedge clk);
        if (use_b) cap_in_b = level; else cap_in_a = level;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual expired expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 count", count_o, 0);
        check("R1 capture", capture_o, 0);
        check("R1 flags", flags_o, 0);
        check("R1 irq", irq_o, 0);

        // R4 R5 R2: vector table driven with external rising ticks
        for (int v = 0; v < NVEC; v++) begin
            wr(3'd0, 16'h0000);
            wr(3'd1, VECS[v].top);
            wr(3'd5, VECS[v].cmp_a);
            wr(3'd6, VECS[v].cmp_b);
            wr(3'd2, VECS[v].start);
            wr(3'd4, 16'h000F);
            wr(3'd0, {13'd0, VECS[v].down, 2'b10});
            pulse_ext(int'(VECS[v].steps));
            wr(3'd0, 16'h0000);
            check($sformatf("R4 count vec%0d", v), count_o, VECS[v].exp_count);
            check($sformatf("R5 flags vec%0d", v), flags_o, VECS[v].exp_flags);
        end

        // R3: stopped timer ignores the external input
        wr(3'd1, 16'd1000);
        wr(3'd5, 16'h0011);
        wr(3'd6, 16'd900);
        wr(3'd2, 16'h0010);
        wr(3'd4, 16'h000F);
        pulse_ext(3);
        repeat (20) @(negedge clk);
        check("R3 count held", count_o, 16'h0010);
        check("R3 no timer flags", flags_o, 0);

        // R2: internal divided tick, 10 periods of PRE_DIV cycles
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h0001);
        repeat (10 * PRE_DIV - 2) @(negedge clk);
        wr(3'd0, 16'h0000);
        check("R2 prescaled steps", count_o, 10);

        // R2: falling-edge external source
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h0003);
        pulse_ext(3);
        wr(3'd0, 16'h0000);
        check("R2 falling steps", count_o, 3);

        // R6: staged compare value waits for the wrap
        wr(3'd1, 16'd9);
        wr(3'd5, 16'd3);
        wr(3'd6, 16'd100);
        wr(3'd2, 16'd0);
        wr(3'd4, 16'h000F);
        wr(3'd0, 16'h0002);
        pulse_ext(2);
        wr(3'd5, 16'd6);
        pulse_ext(2);
        check("R6 old live value still matches", flags_o, 4'b0010);
        wr(3'd4, 16'h000F);
        pulse_ext(2);
        check("R6 staged value not yet live", flags_o, 4'b0000);
        pulse_ext(10);
        check("R6 staged value live after wrap", flags_o, 4'b0011);
        check("R6 count after wrap", count_o, 6);
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'd1);
        wr(3'd2, 16'd0);
        wr(3'd4, 16'h000F);
        wr(3'd0, 16'h0002);
        pulse_ext(1);
        check("R6 stopped write is live at once", flags_o, 4'b0010);

        // R9: same-cycle set and clear keep the flag
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd100);
        wr(3'd5, 16'd5);
        wr(3'd2, 16'd4);
        wr(3'd4, 16'h000F);
        wr(3'd0, 16'h0002);
        ext_clk_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h000F;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        ext_clk_in = 1'b0;
        repeat (4) @(negedge clk);
        wr(3'd0, 16'h0000);
        check("R9 set beats clear", flags_o, 4'b0010);

        // R10: interrupt gating by mask
        wr(3'd3, 16'h0000);
        check("R10 mask off", irq_o, 0);
        wr(3'd3, 16'h000F);
        check("R10 mask on", irq_o, 4'b0010);
        wr(3'd3, 16'h0001);
        check("R10 other mask bit", irq_o, 0);

        // R9: write-one-to-clear is per bit
        wr(3'd4, 16'h0001);
        check("R9 unrelated clear", flags_o, 4'b0010);
        wr(3'd4, 16'h0002);
        check("R9 clear", flags_o, 0);

        // R7 R11: capture from pin A rising, counter stopped
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'h1234);
        check("R11 direct load", count_o, 16'h1234);
        hold_pin(1'b0, 1'b1, 10);
        check("R7 capture flag A", flags_o, 4'b1000);
        check("R7 capture value A", capture_o, 16'h1234);
        hold_pin(1'b0, 1'b0, 10);
        wr(3'd4, 16'h000F);
        hold_pin(1'b1, 1'b1, 10);
        hold_pin(1'b1, 1'b0, 10);
        check("R7 unselected pin ignored", flags_o, 0);

        // R7: pin B on falling edge
        wr(3'd2, 16'h0BEE);
        wr(3'd0, 16'h0018);
        repeat (10) @(negedge clk);
        hold_pin(1'b1, 1'b1, 10);
        check("R7 rising ignored in falling mode", flags_o, 0);
        hold_pin(1'b1, 1'b0, 10);
        check("R7 falling capture flag", flags_o, 4'b1000);
        check("R7 falling capture value", capture_o, 16'h0BEE);

        // R8: glitch filter
        wr(3'd4, 16'h000F);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0042);
        hold_pin(1'b0, 1'b1, 2);
        hold_pin(1'b0, 1'b0, 10);
        check("R8 short pulse flag", flags_o, 0);
        check("R8 short pulse value", capture_o, 16'h0BEE);
        hold_pin(1'b0, 1'b1, 6);
        hold_pin(1'b0, 1'b0, 10);
        check("R8 long pulse flag", flags_o, 4'b1000);
        check("R8 long pulse value", capture_o, 16'h0042);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule